// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block captures a start address on a burst-start strobe and then produces the array address for each beat of a four-beat burst. The upper address bits stay as loaded. The low two bits come from a 2-bit beat counter, mapped to an address in one of two orders. The order is chosen by a mode input that is captured with the address.

A burst can be opened from two sides. The processor-side strobe is qualified by the primary chip enable. The controller-side strobe loads the address whatever the state of the chip enable. After the load, the beat counter steps only on clock edges where the advance strobe is asserted. Otherwise the address is held. All inputs are sampled on the rising clock edge. The output comes from registered state, so it changes in the cycle after the edge that sampled the stimulus.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, and after its release until the first load or advance, addr_o reads 0.
- R2: A rising edge that sees ads_proc_ni low with ce_ni low loads addr_i, so addr_o equals the sampled addr_i after that edge.
- R3: A rising edge that sees ads_ctrl_ni low loads addr_i, whatever the level of ce_ni.
- R4: ads_proc_ni low is ignored while ce_ni is high. With no other strobe asserted on that edge, addr_o keeps its value.
- R5: With mode 0 (linear) captured at the load, the low two bits of addr_o after n advances equal (start low bits + n) mod 4.
- R6: With mode 1 (interleaved) captured at the load, the low two bits of addr_o after n advances equal the start low bits XOR (n mod 4).
- R7: The beat advances only on edges where adv_ni is low. On an edge with no load and adv_ni high, addr_o is unchanged.
- R8: Bits above bit 1 of addr_o never change except on a load. After four advances the burst wraps back to the start address.
- R9: A load on the same edge as an advance wins: the beat restarts at zero and addr_o equals addr_i. The mode is sampled only on a load edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | External start address |
| ads_proc_ni | input | 1 | Processor-side burst start, active low, qualified by ce_ni |
| ads_ctrl_ni | input | 1 | Controller-side burst start, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce_ni | input | 1 | Primary chip enable, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current array address |

## Verification
The checker assumes every input is a known 0 or 1 at each rising edge. It also assumes the mode seen on a load edge is the order that governs the rest of that burst. Changes to mode_i between loads are therefore not taken as a reason for the address to move. The bench changes inputs only on the falling edge. It keeps mode_i constant through each burst, except in the one scenario that changes mode_i mid-burst to show it has no effect. Each burst starts from a deliberate load, so the beat positions the checker tracks always begin from a known start.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  function automatic logic [BEAT_W-1:0] map_low(
    input order_e            ord,
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat
  );
    if (ord == ORD_INTERLEAVE) return start ^ beat;
    return start + beat;
  endfunction
endpackage

// File: rtl/burst_start_ctl.sv
module burst_start_ctl (
  input  logic ads_proc_ni,
  input  logic ads_ctrl_ni,
  input  logic ce_ni,
  input  logic adv_ni,
  output logic load_o,
  output logic step_o
);
  logic proc_go;

  // processor strobe is only honoured when the primary enable is active
  assign proc_go = ~ads_proc_ni & ~ce_ni;
  assign load_o  = proc_go | ~ads_ctrl_ni;
  assign step_o  = ~load_o & ~adv_ni;
endmodule

// File: rtl/burst_counter.sv
module burst_counter #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] base_o,
  output order_e            ord_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      ord_o  <= ORD_LINEAR;
    end else if (load_i) begin
      base_o <= addr_i;
      ord_o  <= order_e'(mode_i);
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ads_proc_ni,
  input  logic              ads_ctrl_ni,
  input  logic              adv_ni,
  input  logic              ce_ni,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic              step;
  logic [BEAT_W-1:0] beat;
  logic [ADDR_W-1:0] base;
  order_e            ord;

  burst_start_ctl u_ctl (
    .ads_proc_ni (ads_proc_ni),
    .ads_ctrl_ni (ads_ctrl_ni),
    .ce_ni       (ce_ni),
    .adv_ni      (adv_ni),
    .load_o      (load),
    .step_o      (step)
  );

  burst_counter #(.W(BEAT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .inc_i  (step),
    .cnt_o  (beat)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (addr_i),
    .mode_i (mode_i),
    .base_o (base),
    .ord_o  (ord)
  );

  // upper bits pass straight from the base register, no carry from the beat
  assign addr_o[ADDR_W-1:BEAT_W] = base[ADDR_W-1:BEAT_W];
  assign addr_o[BEAT_W-1:0]      = map_low(ord, base[BEAT_W-1:0], beat);

  if (HI_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed BEAT_W");
  end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int unsigned ADDR_W = 21
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ads_proc_ni,
  input logic              ads_ctrl_ni,
  input logic              adv_ni,
  input logic              ce_ni,
  input logic              mode_i,
  input logic [ADDR_W-1:0] addr_o
);
  logic       load_ev;
  logic       mode_q;
  logic [1:0] start_lo;
  logic [1:0] beat_q;

  assign load_ev = (!ads_proc_ni && !ce_ni) || !ads_ctrl_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 1'b0;
      start_lo <= 2'd0;
      beat_q   <= 2'd0;
    end else if (load_ev) begin
      mode_q   <= mode_i;
      start_lo <= addr_i[1:0];
      beat_q   <= 2'd0;
    end else if (!adv_ni) begin
      beat_q   <= beat_q + 2'd1;
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk_i) !rst_ni |=> (addr_o == '0 || !rst_ni));

  p_proc_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_proc_ni && !ce_ni) |=> addr_o == $past(addr_i));

  p_ctrl_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ads_ctrl_ni |=> addr_o == $past(addr_i));

  p_proc_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_proc_ni && ce_ni && ads_ctrl_ni && adv_ni) |=> $stable(addr_o));

  p_linear_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ev && !adv_ni && !mode_q) |=> addr_o[1:0] == $past(addr_o[1:0]) + 2'd1);

  p_interleave_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> addr_o[1:0] == (start_lo ^ beat_q));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ev && adv_ni) |=> $stable(addr_o));

  p_upper_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ev |=> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]));

  p_load_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ev && !adv_ni) |=> addr_o == $past(addr_i));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int unsigned ADDR_W = 21;
  localparam int unsigned WD_CYC = 5000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic              proc_n = 1'b1, ctrl_n = 1'b1, adv_n = 1'b1, ce_n = 1'b0, mode = 1'b0;
  logic [ADDR_W-1:0] addr_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_in), .ads_proc_ni(proc_n),
    .ads_ctrl_ni(ctrl_n), .adv_ni(adv_n), .ce_ni(ce_n), .mode_i(mode), .addr_o(addr_out)
  );

  task automatic check(input string tag, input logic [ADDR_W-1:0] exp);
    checks++;
    if (addr_out !== exp) begin
      errors++;
      $display("FAIL %s: addr_o=%h expected %h", tag, addr_out, exp);
    end
  endtask

  // drive on falling edge, let the rising edge act, sample mid-high phase
  task automatic cyc(input logic p, input logic c, input logic a, input logic ce,
                     input logic m, input logic [ADDR_W-1:0] ad);
    @(negedge clk);
    proc_n = p; ctrl_n = c; adv_n = a; ce_n = ce; mode = m; addr_in = ad;
    @(posedge clk);
    #5;
  endtask

  function automatic logic [ADDR_W-1:0] lin(input logic [ADDR_W-1:0] s, input int n);
    return {s[ADDR_W-1:2], 2'(s[1:0] + 2'(n))};
  endfunction

  function automatic logic [ADDR_W-1:0] ilv(input logic [ADDR_W-1:0] s, input int n);
    return {s[ADDR_W-1:2], 2'(s[1:0] ^ 2'(n))};
  endfunction

  task automatic t_reset;
    #5 check("R1 during reset", '0);
    @(negedge clk); rst_n = 1'b1;
    cyc(1, 1, 1, 0, 0, 21'h1FFFFF);
    check("R1 after release", '0);
  endtask

  task automatic t_linear;
    logic [ADDR_W-1:0] s = 21'h0A5F2E;
    cyc(0, 1, 1, 0, 0, s);
    check("R2 proc load", s);
    for (int n = 1; n <= 4; n++) begin
      cyc(1, 1, 0, 0, 0, 21'h155555);
      check(n == 4 ? "R8 linear wrap" : "R5 linear beat", lin(s, n));
    end
  endtask

  task automatic t_interleave;
    logic [ADDR_W-1:0] s = 21'h13C4D5;
    cyc(1, 0, 1, 1, 1, s);
    check("R3 ctrl load with ce high", s);
    for (int n = 1; n <= 4; n++) begin
      cyc(1, 1, 0, 1, 1, 21'h0);
      check(n == 4 ? "R8 interleave wrap" : "R6 interleave beat", ilv(s, n));
    end
  endtask

  task automatic t_hold_gate;
    logic [ADDR_W-1:0] s = 21'h00F03;
    cyc(1, 0, 1, 0, 0, s);
    cyc(1, 1, 0, 0, 0, 21'h0);
    check("R5 step from 3", lin(s, 1));
    cyc(1, 1, 1, 0, 0, 21'h1ABCDE);
    cyc(1, 1, 1, 0, 1, 21'h1ABCDE);
    check("R7 hold no advance", lin(s, 1));
    cyc(0, 1, 1, 1, 0, 21'h1ABCDE);
    check("R4 proc ignored with ce high", lin(s, 1));
    cyc(1, 1, 0, 0, 1, 21'h0);
    check("R9 mode change mid-burst ignored", lin(s, 2));
  endtask

  task automatic t_upper_priority;
    logic [ADDR_W-1:0] s = 21'h1FFFFF;
    logic [ADDR_W-1:0] t = 21'h000002;
    cyc(0, 1, 1, 0, 0, s);
    cyc(1, 1, 0, 0, 0, 21'h0);
    check("R8 no carry into upper bits", lin(s, 1));
    cyc(0, 1, 0, 0, 1, t);
    check("R9 load wins over advance", t);
    cyc(1, 1, 0, 0, 0, 21'h0);
    check("R9 mode latched at load", ilv(t, 1));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_linear();
    t_interleave();
    t_hold_gate();
    t_upper_priority();
    finish_run();
  end
endmodule